// File: doc/BRIEF.md
# Set/Clear Memory-Mapped GPIO Port

This block is a general-purpose I/O port of `NPINS` pins (16 by default) run from a small bank of memory-mapped registers. Software can write the function-enable, data and input-enable words directly. It can also write a 32-bit pin-mux word. The data word can additionally be changed bit by bit through a write-one-to-set alias and a write-one-to-clear alias. The direction word has no address of its own. It can be changed only through its own set alias and clear alias, and it reads back through either of them.

After certain writes the port refreshes its pin outputs. Every pin whose input-enable bit is 0 is driven with its data bit, and a per-pin update strobe marks which pins were driven. On the input side each pin presents a multi-bit level, and any nonzero level counts as 1. A pin's level is taken into a registered input-status word only when three conditions hold: the pin is an input, its input is enabled, and its function is enabled. A pin that fails any of these keeps its status bit unchanged.

Each register has a fixed access width. An access of the wrong width, or an access to an address outside the map, raises a one-cycle error flag, changes nothing and reads as zero.

Top module: `scg_port`

## Requirements
- R1: After reset every register is zero, and `pin_out`, `pin_upd`, `in_stat`, `bus_err` and `bus_rdata` are all zero.
- R2: The mux word at byte offset 0x1C needs `bus_sz32`=1, and every other register needs `bus_sz32`=0. An access of the wrong width sets `bus_err`, changes no register and reads as zero.
- R3: An access with `bus_addr[1:0]`≠0 or `bus_addr`≥0x20 sets `bus_err`, changes no register and reads as zero.
- R4: Writes to function enable (0x00), data (0x04) and input enable (0x18) replace the low `NPINS` bits of the register. A write to the mux word (0x1C) replaces all 32 bits. Each of these reads back what was written.
- R5: A write to 0x08 ORs the written bits into data. A write to 0x0C clears each data bit that is written as 1. Reads of 0x04, 0x08 and 0x0C all return data.
- R6: A write to 0x10 ORs the written bits into direction. A write to 0x14 clears each direction bit that is written as 1. Reads of 0x10 and 0x14 return direction (1 = output).
- R7: A legal write to 0x04, 0x08, 0x0C or 0x10 triggers an output refresh. One clock after the write is accepted, `pin_upd` equals the inverse of input enable for one cycle. Each pin whose input-enable bit is 0 then drives its data bit on `pin_out`, and the other pins hold their previous value.
- R8: Writes to 0x14, 0x00, 0x18 and 0x1C trigger no refresh: `pin_upd` stays zero and `pin_out` keeps its value.
- R9: On each clock, `in_stat[i]` loads the level of pin i only when direction bit i is 0, input-enable bit i is 1 and function-enable bit i is 1. Otherwise the bit holds its value.
- R10: Each pin's level is a field of `LVL_W` bits at `pin_lvl[i*LVL_W +: LVL_W]`, and any nonzero field counts as level 1.
- R11: `bus_rdata` and `bus_err` are registered. Both are valid the cycle after the access is presented, and both are zero when no access was made.
- R12: Accepted input levels never change the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (wins over a read) |
| bus_sz32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| bus_err | output | 1 | Registered error flag for a bad width or address |
| pin_out | output | NPINS | Driven pin values |
| pin_upd | output | NPINS | Per-pin drive-update strobe |
| pin_lvl | input | NPINS*LVL_W | Incoming pin levels, one field per pin |
| in_stat | output | NPINS | Registered accepted input levels |

## Verification
Register updates, `bus_err` and `bus_rdata` all appear at the edge that samples the access. The bench presents each access on a falling edge and reads the results on the next falling edge. An output refresh lands one edge later than the register update, so the bench waits one more falling edge before it compares `pin_upd` and `pin_out` with the values a bench-side register model predicts; that same sample confirms zero updates after non-triggering writes. Pin levels are changed on a falling edge, and `in_stat` is compared one full cycle later.

// File: rtl/scg_pkg.sv
package scg_pkg;

   // Register index = byte address [4:2]; the order fixes the map layout.
   typedef enum logic [2:0] {
      RG_FEN  = 3'd0,
      RG_DAT  = 3'd1,
      RG_DSET = 3'd2,
      RG_DCLR = 3'd3,
      RG_OSET = 3'd4,
      RG_OCLR = 3'd5,
      RG_IEN  = 3'd6,
      RG_MUX  = 3'd7
   } scg_reg_e;

   localparam int STRIDE_LG = 2;
   localparam int MAP_LG    = 5;

   typedef struct packed {
      logic     hit;    // legal access
      logic     bad;    // access with wrong width or address
      logic     is_wr;  // write (otherwise read)
      scg_reg_e idx;
   } scg_acc_t;

   function automatic logic scg_refresh_trig(scg_reg_e r);
      return (r == RG_DAT) || (r == RG_DSET) || (r == RG_DCLR) || (r == RG_OSET);
   endfunction

endpackage

// File: rtl/scg_decode.sv
module scg_decode
   import scg_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              sz32,
   output scg_acc_t          acc
);

   logic     aligned;
   logic     in_map;
   logic     width_ok;
   logic     active;
   scg_reg_e idx;

   assign idx     = scg_reg_e'(addr[MAP_LG-1:STRIDE_LG]);
   assign aligned = (addr[STRIDE_LG-1:0] == '0);
   assign active  = rd | wr;

   generate
      if (ADDR_W > MAP_LG) begin : g_hi
         assign in_map = (addr[ADDR_W-1:MAP_LG] == '0);
      end else begin : g_nohi
         assign in_map = 1'b1;
      end
   endgenerate

   assign width_ok = (idx == RG_MUX) ? sz32 : ~sz32;

   always_comb begin
      acc.idx   = idx;
      acc.is_wr = wr;
      acc.hit   = active & aligned & in_map & width_ok;
      acc.bad   = active & ~(aligned & in_map & width_ok);
   end

endmodule

// File: rtl/scg_regs.sv
module scg_regs
   import scg_pkg::*;
#(
   parameter int NPINS = 16,
   parameter int MUX_W = 32,
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  scg_acc_t         acc,
   input  logic [BUS_W-1:0] wdata,
   output logic [NPINS-1:0] fer_q,
   output logic [NPINS-1:0] data_q,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] inen_q,
   output logic [BUS_W-1:0] rdata_q,
   output logic             err_q,
   output logic             refresh_q
);

   logic [MUX_W-1:0] mux_q;
   logic [NPINS-1:0] wv;
   logic [BUS_W-1:0] rd_next;
   logic             do_wr;

   assign wv    = wdata[NPINS-1:0];
   assign do_wr = acc.hit & acc.is_wr;

   always_comb begin
      rd_next = '0;
      if (acc.hit && !acc.is_wr) begin
         unique case (acc.idx)
            RG_FEN:                  rd_next[NPINS-1:0] = fer_q;
            RG_DAT, RG_DSET, RG_DCLR: rd_next[NPINS-1:0] = data_q;
            RG_OSET, RG_OCLR:        rd_next[NPINS-1:0] = dir_q;
            RG_IEN:                  rd_next[NPINS-1:0] = inen_q;
            RG_MUX:                  rd_next[MUX_W-1:0] = mux_q;
            default:                 rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fer_q     <= '0;
         data_q    <= '0;
         dir_q     <= '0;
         inen_q    <= '0;
         mux_q     <= '0;
         rdata_q   <= '0;
         err_q     <= 1'b0;
         refresh_q <= 1'b0;
      end else begin
         err_q     <= acc.bad;
         rdata_q   <= rd_next;
         refresh_q <= do_wr & scg_refresh_trig(acc.idx);
         if (do_wr) begin
            unique case (acc.idx)
               RG_FEN:  fer_q  <= wv;
               RG_DAT:  data_q <= wv;
               RG_DSET: data_q <= data_q | wv;
               RG_DCLR: data_q <= data_q & ~wv;
               RG_OSET: dir_q  <= dir_q | wv;
               RG_OCLR: dir_q  <= dir_q & ~wv;
               RG_IEN:  inen_q <= wv;
               RG_MUX:  mux_q  <= wdata[MUX_W-1:0];
               default: ;
            endcase
         end
      end
   end

   // R2/R3: a rejected access leaves every register untouched
   p_bad_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc.bad) |-> (data_q == $past(data_q)) && (dir_q == $past(dir_q)) &&
                         (fer_q == $past(fer_q)) && (inen_q == $past(inen_q)) &&
                         (mux_q == $past(mux_q)));

   p_err_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (rdata_q == '0));

   p_dset_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(do_wr && acc.idx == RG_DSET) |->
         ((data_q & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));

   p_dclr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(do_wr && acc.idx == RG_DCLR) |-> ((data_q & $past(wdata[NPINS-1:0])) == '0));

   p_oclr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(do_wr && acc.idx == RG_OCLR) |-> ((dir_q & $past(wdata[NPINS-1:0])) == '0));

   p_err_needs_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> $past(acc.bad));

endmodule

// File: rtl/scg_drive.sv
module scg_drive #(
   parameter int NPINS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             refresh,
   input  logic [NPINS-1:0] data,
   input  logic [NPINS-1:0] inen,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_upd
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out <= '0;
         pin_upd <= '0;
      end else if (refresh) begin
         pin_out <= (pin_out & inen) | (data & ~inen);
         pin_upd <= ~inen;
      end else begin
         pin_upd <= '0;
      end
   end

   p_upd_after_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_upd != '0) |-> $past(refresh));

   p_hold_no_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(refresh) |-> (pin_out == $past(pin_out)) && (pin_upd == '0));

endmodule

// File: rtl/scg_ingate.sv
module scg_ingate #(
   parameter int NPINS = 16,
   parameter int LVL_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPINS*LVL_W-1:0] pin_lvl,
   input  logic [NPINS-1:0]       dir,
   input  logic [NPINS-1:0]       inen,
   input  logic [NPINS-1:0]       fer,
   output logic [NPINS-1:0]       in_stat
);

   logic [NPINS-1:0] lvl_bit;
   logic [NPINS-1:0] accept;

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign lvl_bit[i] = |pin_lvl[i*LVL_W +: LVL_W];
      assign accept[i]  = ~dir[i] & inen[i] & fer[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          in_stat[i] <= 1'b0;
         else if (accept[i])  in_stat[i] <= lvl_bit[i];
      end

      p_ignored_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(accept[i]) |-> (in_stat[i] == $past(in_stat[i])));

      p_accept_norm_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(accept[i]) |-> (in_stat[i] == ($past(pin_lvl[i*LVL_W +: LVL_W]) != '0)));
   end

endmodule

// File: rtl/scg_port.sv
module scg_port
   import scg_pkg::*;
#(
   parameter int NPINS  = 16,
   parameter int LVL_W  = 2,
   parameter int ADDR_W = 6,
   parameter int BUS_W  = 32,
   parameter int MUX_W  = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_rd,
   input  logic                   bus_wr,
   input  logic                   bus_sz32,
   input  logic [BUS_W-1:0]       bus_wdata,
   output logic [BUS_W-1:0]       bus_rdata,
   output logic                   bus_err,
   output logic [NPINS-1:0]       pin_out,
   output logic [NPINS-1:0]       pin_upd,
   input  logic [NPINS*LVL_W-1:0] pin_lvl,
   output logic [NPINS-1:0]       in_stat
);

   generate
      if (NPINS < 1 || NPINS > 16) begin : g_chk_np
         $error("scg_port: NPINS must be 1..16 for 16-bit registers");
      end
      if (LVL_W < 1) begin : g_chk_lvl
         $error("scg_port: LVL_W must be at least 1");
      end
      if (ADDR_W < MAP_LG) begin : g_chk_addr
         $error("scg_port: ADDR_W too small for the register map");
      end
      if (MUX_W > BUS_W || BUS_W < 16) begin : g_chk_bus
         $error("scg_port: bus must hold the mux word and a 16-bit register");
      end
   endgenerate

   scg_acc_t         acc;
   logic [NPINS-1:0] fer_q, data_q, dir_q, inen_q;
   logic             refresh_q;

   scg_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (bus_addr),
      .rd   (bus_rd),
      .wr   (bus_wr),
      .sz32 (bus_sz32),
      .acc  (acc)
   );

   scg_regs #(.NPINS(NPINS), .MUX_W(MUX_W), .BUS_W(BUS_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .wdata     (bus_wdata),
      .fer_q     (fer_q),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .inen_q    (inen_q),
      .rdata_q   (bus_rdata),
      .err_q     (bus_err),
      .refresh_q (refresh_q)
   );

   scg_drive #(.NPINS(NPINS)) u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .refresh (refresh_q),
      .data    (data_q),
      .inen    (inen_q),
      .pin_out (pin_out),
      .pin_upd (pin_upd)
   );

   scg_ingate #(.NPINS(NPINS), .LVL_W(LVL_W)) u_ingate (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_lvl (pin_lvl),
      .dir     (dir_q),
      .inen    (inen_q),
      .fer     (fer_q),
      .in_stat (in_stat)
   );

   // R8: a legal direction-clear write produces no update strobe two edges later
   p_oclr_no_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc.hit && acc.is_wr && acc.idx == RG_OCLR) |=> (pin_upd == '0));

   // R12: the input path never writes data
   p_data_only_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(acc.hit && acc.is_wr) |-> (data_q == $past(data_q)));

endmodule

// File: tb/scg_port_bench.sv
`timescale 1ns/1ps
module scg_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_sz32 = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [15:0] pin_out;
   logic [15:0] pin_upd;
   logic [31:0] pin_lvl = '0;
   logic [15:0] in_stat;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   // bench-side register model
   logic [15:0] m_fer = '0, m_dat = '0, m_dir = '0, m_ien = '0, m_pout = '0;
   logic [31:0] m_mux = '0;

   always #5 clk = ~clk;

   scg_port u_scg_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_sz32(bus_sz32), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .pin_out(pin_out), .pin_upd(pin_upd), .pin_lvl(pin_lvl), .in_stat(in_stat)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Write, then check error flag, model update and output refresh (R7/R8)
   task automatic wr_reg(input logic [5:0] a, input logic s32, input logic [31:0] d,
                         input logic exp_err, input string tag);
      logic trig;
      @(negedge clk);
      bus_addr = a; bus_sz32 = s32; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk({tag, " err"}, {31'd0, bus_err}, {31'd0, exp_err});
      trig = 1'b0;
      if (!exp_err) begin
         case (a)
            6'h00: m_fer = d[15:0];
            6'h04: begin m_dat = d[15:0];          trig = 1'b1; end
            6'h08: begin m_dat = m_dat | d[15:0];  trig = 1'b1; end
            6'h0C: begin m_dat = m_dat & ~d[15:0]; trig = 1'b1; end
            6'h10: begin m_dir = m_dir | d[15:0];  trig = 1'b1; end
            6'h14: m_dir = m_dir & ~d[15:0];
            6'h18: m_ien = d[15:0];
            6'h1C: m_mux = d;
            default: ;
         endcase
      end
      if (trig) m_pout = (m_pout & m_ien) | (m_dat & ~m_ien);
      @(negedge clk);
      chk({tag, " R7/R8 pin_upd"}, {16'd0, pin_upd}, trig ? {16'd0, ~m_ien} : 32'd0);
      chk({tag, " R7/R8 pin_out"}, {16'd0, pin_out}, {16'd0, m_pout});
   endtask

   task automatic rd_reg(input logic [5:0] a, input logic s32, input logic [31:0] exp,
                         input logic exp_err, input string tag);
      @(negedge clk);
      bus_addr = a; bus_sz32 = s32; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      chk({tag, " rdata"}, bus_rdata, exp);
      chk({tag, " err"}, {31'd0, bus_err}, {31'd0, exp_err});
   endtask

   task automatic drive_pins(input logic [31:0] v, input logic [15:0] exp, input string tag);
      @(negedge clk);
      pin_lvl = v;
      @(negedge clk);
      chk({tag, " in_stat"}, {16'd0, in_stat}, {16'd0, exp});
   endtask

   task automatic t_reset;
      chk("R1 pin_out", {16'd0, pin_out}, 32'd0);
      chk("R1 pin_upd", {16'd0, pin_upd}, 32'd0);
      chk("R1 in_stat", {16'd0, in_stat}, 32'd0);
      chk("R11 idle err", {31'd0, bus_err}, 32'd0);
      chk("R11 idle rdata", bus_rdata, 32'd0);
      rd_reg(6'h00, 1'b0, 32'd0, 1'b0, "R1 fer");
      rd_reg(6'h04, 1'b0, 32'd0, 1'b0, "R1 data");
      rd_reg(6'h14, 1'b0, 32'd0, 1'b0, "R1 dir");
      rd_reg(6'h18, 1'b0, 32'd0, 1'b0, "R1 inen");
      rd_reg(6'h1C, 1'b1, 32'd0, 1'b0, "R1 mux");
   endtask

   task automatic t_direct;
      wr_reg(6'h00, 1'b0, 32'h0000_A5A5, 1'b0, "R4 fer wr");
      rd_reg(6'h00, 1'b0, 32'h0000_A5A5, 1'b0, "R4 fer rd");
      wr_reg(6'h1C, 1'b1, 32'hDEAD_BEEF, 1'b0, "R4 mux wr");
      rd_reg(6'h1C, 1'b1, 32'hDEAD_BEEF, 1'b0, "R4 mux rd");
      wr_reg(6'h18, 1'b0, 32'hFFFF_0F0F, 1'b0, "R4 inen wr");
      rd_reg(6'h18, 1'b0, 32'h0000_0F0F, 1'b0, "R4 inen rd");
      wr_reg(6'h18, 1'b0, 32'h0000_0000, 1'b0, "R4 inen zero");
   endtask

   task automatic t_data_alias;
      wr_reg(6'h04, 1'b0, 32'h0000_00F0, 1'b0, "R5 data wr");
      wr_reg(6'h08, 1'b0, 32'h0000_0F00, 1'b0, "R5 dset");
      rd_reg(6'h04, 1'b0, 32'h0000_0FF0, 1'b0, "R5 rd data");
      rd_reg(6'h08, 1'b0, 32'h0000_0FF0, 1'b0, "R5 rd dset");
      wr_reg(6'h0C, 1'b0, 32'h0000_00F0, 1'b0, "R5 dclr");
      rd_reg(6'h0C, 1'b0, 32'h0000_0F00, 1'b0, "R5 rd dclr");
   endtask

   task automatic t_dir_alias;
      wr_reg(6'h10, 1'b0, 32'h0000_1234, 1'b0, "R6 oset");
      rd_reg(6'h10, 1'b0, 32'h0000_1234, 1'b0, "R6 rd oset");
      wr_reg(6'h14, 1'b0, 32'h0000_0034, 1'b0, "R6 oclr");
      rd_reg(6'h14, 1'b0, 32'h0000_1200, 1'b0, "R6 rd oclr");
      rd_reg(6'h10, 1'b0, 32'h0000_1200, 1'b0, "R6 rd oset2");
   endtask

   task automatic t_width;
      wr_reg(6'h04, 1'b1, 32'h0000_FFFF, 1'b1, "R2 data 32b wr");
      rd_reg(6'h04, 1'b0, {16'd0, m_dat}, 1'b0, "R2 data unchanged");
      rd_reg(6'h1C, 1'b0, 32'd0, 1'b1, "R2 mux 16b rd");
      wr_reg(6'h1C, 1'b0, 32'h1111_1111, 1'b1, "R2 mux 16b wr");
      rd_reg(6'h1C, 1'b1, m_mux, 1'b0, "R2 mux unchanged");
   endtask

   task automatic t_bad_offset;
      wr_reg(6'h20, 1'b0, 32'h0000_FFFF, 1'b1, "R3 wr 0x20");
      wr_reg(6'h06, 1'b0, 32'h0000_FFFF, 1'b1, "R3 wr 0x06");
      rd_reg(6'h02, 1'b0, 32'd0, 1'b1, "R3 rd 0x02");
      rd_reg(6'h3C, 1'b1, 32'd0, 1'b1, "R3 rd 0x3C");
      rd_reg(6'h04, 1'b0, {16'd0, m_dat}, 1'b0, "R3 data unchanged");
      rd_reg(6'h00, 1'b0, {16'd0, m_fer}, 1'b0, "R3 fer unchanged");
   endtask

   task automatic t_refresh;
      wr_reg(6'h18, 1'b0, 32'h0000_00FF, 1'b0, "R8 inen no refresh");
      wr_reg(6'h04, 1'b0, 32'h0000_5A5A, 1'b0, "R7 data refresh");
      wr_reg(6'h10, 1'b0, 32'h0000_0001, 1'b0, "R7 oset refresh");
      wr_reg(6'h0C, 1'b0, 32'h0000_0F00, 1'b0, "R7 dclr refresh");
      wr_reg(6'h14, 1'b0, 32'h0000_0001, 1'b0, "R8 oclr no refresh");
      wr_reg(6'h00, 1'b0, 32'h0000_0000, 1'b0, "R8 fer no refresh");
      wr_reg(6'h1C, 1'b1, 32'h0000_0000, 1'b0, "R8 mux no refresh");
   endtask

   task automatic t_inputs;
      // pin0 accepted; pin1 output; pin2 input disabled; pin3 function disabled
      wr_reg(6'h00, 1'b0, 32'h0000_0007, 1'b0, "R9 cfg fer");
      wr_reg(6'h18, 1'b0, 32'h0000_000B, 1'b0, "R9 cfg inen");
      wr_reg(6'h14, 1'b0, 32'h0000_FFFF, 1'b0, "R9 cfg oclr");
      wr_reg(6'h10, 1'b0, 32'h0000_0002, 1'b0, "R9 cfg oset");
      drive_pins(32'h0000_00AA, 16'h0001, "R9 gate");
      drive_pins(32'h0000_0000, 16'h0000, "R9 low");
      drive_pins(32'h0000_0001, 16'h0001, "R10 lvl 01");
      drive_pins(32'h0000_0000, 16'h0000, "R10 lvl 00");
      drive_pins(32'h0000_0003, 16'h0001, "R10 lvl 11");
      wr_reg(6'h14, 1'b0, 32'h0000_0002, 1'b0, "R9 pin1 input");
      drive_pins(32'h0000_0004, 16'h0002, "R9 pin1 accept");
      wr_reg(6'h10, 1'b0, 32'h0000_0002, 1'b0, "R9 pin1 output");
      drive_pins(32'h0000_0000, 16'h0002, "R9 pin1 hold");
      rd_reg(6'h04, 1'b0, {16'd0, m_dat}, 1'b0, "R12 data untouched");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_data_alias();
      t_dir_alias();
      t_width();
      t_bad_offset();
      t_refresh();
      t_inputs();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog R1..all actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule